// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and a calendar in packed BCD bytes: hundredths of a second, seconds, minutes, hours, day of month, day of week, month and a two-digit year. A free-running oscillator pulse feeds an internal prescaler. Every `PRESC_DIV` pulses the prescaler issues one hundredth-of-a-second step. That step ripples through the fields as each one rolls over, and the day-of-month wrap follows the current month's length and the leap-year rule for years 00 to 99.

Software sets the clock in three steps. It raises the stop input, which freezes counting. It then writes the fields through a byte-wide load port and issues the prescaler-clear command, so the next step falls on a clean boundary. Finally it drops stop. The hour field counts either in plain 24-hour BCD or in a 12-hour BCD form with a PM flag. A sticky oscillator-fault flag rides in the top bit of the seconds output and tells software that the time cannot be trusted.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the outputs read hundredths 0x00, seconds 0x80 (fault flag set, value 00), minutes 0x00, hours 0x00, day of month 0x01, day of week 0x00, month 0x01 and year 0x00.
- R2: While stop is low, each group of `PRESC_DIV` oscillator pulses advances the hundredths field by exactly one. The step lands on the clock edge that captures the last pulse of the group.
- R3: Hundredths roll 0x99 to 0x00 and carry into seconds. Seconds and minutes each roll 0x59 to 0x00 and carry into the next field. A units digit of 9 wraps to 0 and increments the tens digit.
- R4: With the 12-hour mode input low, the hour byte holds BCD 00 to 23 and rolls 0x23 to 0x00 with a carry into the day fields.
- R5: With the 12-hour mode input high, bit 5 of the hour byte is PM and bits 4:0 hold BCD 1 to 12. The hour steps 0x12 to 0x01, 0x11 to 0x32, 0x32 to 0x21, and 0x31 to 0x12, and only the last of these carries into the day fields.
- R6: Day of month wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11. In month 0x02 it wraps after 0x29 when the year value is divisible by 4, and after 0x28 otherwise. In all other months it wraps after 0x31.
- R7: Each day carry steps the day of week, which wraps 0x06 to 0x00. A day-of-month wrap steps the month, which wraps 0x12 to 0x01 and carries into the year, which wraps 0x99 to 0x00.
- R8: While stop is high, oscillator pulses are not counted. The time fields and the prescaler position hold, and counting resumes from the held position when stop falls.
- R9: A load with stop high writes the selected field on the next clock edge. The field selects are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 day of week, 6 month and 7 year. A load with stop low is ignored.
- R10: A command byte of 0xA4 returns the prescaler to its start position, so a full `PRESC_DIV` pulses are needed before the next step. Any other command byte has no effect. If the command arrives in the same cycle as a pulse that completes a group, the clear wins and no step occurs.
- R11: The fault flag (seconds output bit 7) is set by the fault input and then holds. It is cleared only by an accepted seconds load whose data bit 7 is 0. If the fault input and such a load arrive in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_pulse_i | input | 1 | One pulse per oscillator period, feeds the prescaler |
| stop_i | input | 1 | High freezes counting and enables loads |
| mode_12h_i | input | 1 | High selects 12-hour hour encoding |
| ld_we_i | input | 1 | Field load strobe |
| ld_sel_i | input | 3 | Field select for a load |
| ld_data_i | input | 8 | BCD load data |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte, 0xA4 clears the prescaler |
| osc_fault_i | input | 1 | Sets the sticky fault flag |
| hsec_o | output | 8 | Hundredths of a second, BCD |
| sec_o | output | 8 | Bit 7 fault flag, bits 6:0 seconds BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, 24-hour BCD or 12-hour BCD with PM at bit 5 |
| mday_o | output | 8 | Day of month, BCD |
| wday_o | output | 8 | Day of week, BCD 0 to 6 |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The prescaler-clear command and the pulse that completes a prescaler group can land in the same cycle. In that case the clear must win and no step may occur. The bench provokes this by sending three pulses, then raising the fourth pulse and the 0xA4 command together. It then expects the hundredths field to stay put through three more pulses and to step only on the fourth after them. A second collision, a fault report in the same cycle as a flag-clearing seconds load, is provoked the same way, and the bench expects the flag to end set while the seconds value still loads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam logic [7:0]  CMD_CLR_PRESC = 8'hA4;

  typedef enum logic [2:0] {
    F_HSEC = 3'd0, F_SEC = 3'd1, F_MIN = 3'd2, F_HOUR = 3'd3,
    F_MDAY = 3'd4, F_WDAY = 3'd5, F_MON = 3'd6, F_YEAR = 3'd7
  } field_e;

  // add one to a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last valid day of a month, both arguments and result in BCD
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] year);
    int yb;
    yb = int'(year[7:4]) * 10 + int'(year[3:0]);
    case (mon)
      8'h02:                      return (yb % 4 == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 328
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          adv;

  assign adv    = pulse_i & ~hold_i;
  assign step_o = adv & ~clr_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i)      cnt_q <= '0;
    else if (adv)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt
  import rtc_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic [7:0] top_i,
  output logic [7:0] q_o,
  output logic       carry_o
);
  logic at_top;
  assign at_top  = (q_o >= top_i);
  assign carry_o = inc_i & at_top;

  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (ld_i)  q_o <= ld_val_i;
    else if (inc_i) q_o <= at_top ? MIN_VAL : bcd_inc(q_o);
  end
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       mode_12h_i,
  output logic [7:0] q_o,
  output logic       carry_o
);
  logic       pm;
  logic [4:0] lo;
  logic [7:0] lo_inc;
  logic [7:0] nxt;
  logic       wrap;

  assign pm     = q_o[5];
  assign lo     = q_o[4:0];
  assign lo_inc = bcd_inc({3'b000, lo});

  always_comb begin
    if (mode_12h_i) begin
      wrap = pm && (lo == 5'h11);
      if (lo == 5'h12)      nxt = {2'b00, pm, 5'h01};
      else if (lo == 5'h11) nxt = {2'b00, ~pm, 5'h12};
      else                  nxt = {2'b00, pm, lo_inc[4:0]};
    end else begin
      wrap = (q_o >= 8'h23);
      nxt  = wrap ? 8'h00 : bcd_inc(q_o);
    end
  end

  assign carry_o = inc_i & wrap;

  always_ff @(posedge clk) begin
    if (rst)        q_o <= 8'h00;
    else if (ld_i)  q_o <= ld_val_i;
    else if (inc_i) q_o <= nxt;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 328
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_pulse_i,
  input  logic       stop_i,
  input  logic       mode_12h_i,
  input  logic       ld_we_i,
  input  logic [2:0] ld_sel_i,
  input  logic [7:0] ld_data_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       osc_fault_i,
  output logic [7:0] hsec_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] mday_o,
  output logic [7:0] wday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  logic [NUM_FIELDS-1:0] ld_vec;
  logic step, presc_clr;
  logic c_hs, c_s, c_m, c_h, c_d, c_w, c_mo, c_y;
  logic [7:0] sec_q, mday_top;
  logic fault_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_ld
    assign ld_vec[i] = ld_we_i & stop_i & (ld_sel_i == 3'(i));
  end

  assign presc_clr = cmd_valid_i && (cmd_byte_i == CMD_CLR_PRESC);

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .pulse_i(osc_pulse_i), .hold_i(stop_i),
    .clr_i(presc_clr), .step_o(step));

  rtc_wrap_cnt u_hsec (
    .clk(clk), .rst(rst), .inc_i(step), .ld_i(ld_vec[F_HSEC]),
    .ld_val_i(ld_data_i), .top_i(8'h99), .q_o(hsec_o), .carry_o(c_hs));

  rtc_wrap_cnt u_sec (
    .clk(clk), .rst(rst), .inc_i(c_hs), .ld_i(ld_vec[F_SEC]),
    .ld_val_i({1'b0, ld_data_i[6:0]}), .top_i(8'h59), .q_o(sec_q),
    .carry_o(c_s));

  rtc_wrap_cnt u_min (
    .clk(clk), .rst(rst), .inc_i(c_s), .ld_i(ld_vec[F_MIN]),
    .ld_val_i(ld_data_i), .top_i(8'h59), .q_o(min_o), .carry_o(c_m));

  rtc_hour_cnt u_hour (
    .clk(clk), .rst(rst), .inc_i(c_m), .ld_i(ld_vec[F_HOUR]),
    .ld_val_i(ld_data_i), .mode_12h_i(mode_12h_i), .q_o(hour_o),
    .carry_o(c_h));

  assign mday_top = month_last_day(mon_o, year_o);

  rtc_wrap_cnt #(.MIN_VAL(8'h01), .RST_VAL(8'h01)) u_mday (
    .clk(clk), .rst(rst), .inc_i(c_h), .ld_i(ld_vec[F_MDAY]),
    .ld_val_i(ld_data_i), .top_i(mday_top), .q_o(mday_o), .carry_o(c_d));

  rtc_wrap_cnt u_wday (
    .clk(clk), .rst(rst), .inc_i(c_h), .ld_i(ld_vec[F_WDAY]),
    .ld_val_i(ld_data_i), .top_i(8'h06), .q_o(wday_o), .carry_o(c_w));

  rtc_wrap_cnt #(.MIN_VAL(8'h01), .RST_VAL(8'h01)) u_mon (
    .clk(clk), .rst(rst), .inc_i(c_d), .ld_i(ld_vec[F_MON]),
    .ld_val_i(ld_data_i), .top_i(8'h12), .q_o(mon_o), .carry_o(c_mo));

  rtc_wrap_cnt u_year (
    .clk(clk), .rst(rst), .inc_i(c_mo), .ld_i(ld_vec[F_YEAR]),
    .ld_val_i(ld_data_i), .top_i(8'h99), .q_o(year_o), .carry_o(c_y));

  // fault report outranks a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || osc_fault_i)                      fault_q <= 1'b1;
    else if (ld_vec[F_SEC] && !ld_data_i[7])     fault_q <= 1'b0;
  end

  assign sec_o = {fault_q, sec_q[6:0]};

  // the year carry and day-of-week carry leave the block unused by design
  logic unused_carries;
  assign unused_carries = c_w ^ c_y ^ sec_q[7];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_pulse_i,
  input logic       stop_i,
  input logic       ld_we_i,
  input logic [2:0] ld_sel_i,
  input logic [7:0] ld_data_i,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_byte_i,
  input logic       osc_fault_i,
  input logic [7:0] hsec_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] mday_o,
  input logic [7:0] wday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o
);
  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !ld_we_i) |=> ($stable(hsec_o) && $stable(min_o) &&
      $stable(hour_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));

  // R9
  run_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_i && !osc_pulse_i) |=> ($stable(hsec_o) && $stable(min_o) &&
      $stable(hour_o) && $stable(wday_o) && $stable(year_o)));

  // R10
  presc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_byte_i == 8'hA4 && !(stop_i && ld_we_i))
      |=> $stable(hsec_o));

  // R11
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    osc_fault_i |=> sec_o[7]);

  // R11
  fault_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sec_o[7]) |-> $past(stop_i && ld_we_i && ld_sel_i == 3'd1 &&
      !ld_data_i[7] && !osc_fault_i));

  // R7
  wday_range_chk: assert property (@(posedge clk) disable iff (rst)
    wday_o <= 8'h06);

  // R3
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_o[6:0] <= 7'h59) && (min_o <= 8'h59));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst(rst), .osc_pulse_i(osc_pulse_i), .stop_i(stop_i),
  .ld_we_i(ld_we_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
  .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i),
  .osc_fault_i(osc_fault_i), .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .mday_o(mday_o), .wday_o(wday_o), .mon_o(mon_o),
  .year_o(year_o));

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int DIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic osc_pulse_i = 0, stop_i = 0, mode_12h_i = 0, ld_we_i = 0;
  logic [2:0] ld_sel_i = 0;
  logic [7:0] ld_data_i = 0, cmd_byte_i = 0;
  logic cmd_valid_i = 0, osc_fault_i = 0;
  logic [7:0] hsec_o, sec_o, min_o, hour_o, mday_o, wday_o, mon_o, year_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bcd_rtc_core #(.PRESC_DIV(DIV)) dut (.*);

  function automatic logic [63:0] mk(input logic [7:0] y, mo, w, d, h, mi, s, hs);
    return {y, mo, w, d, h, mi, s, hs};
  endfunction

  function automatic logic [63:0] now_t();
    return {year_o, mon_o, wday_o, mday_o, hour_o, min_o, sec_o, hsec_o};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    ld_we_i = 1; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk);
    ld_we_i = 0;
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_valid_i = 1; cmd_byte_i = b;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic pulses(input int n);
    if (n > 0) begin
      osc_pulse_i = 1;
      repeat (n) @(negedge clk);
      osc_pulse_i = 0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, w, d, h, mi, s, hs);
    stop_i = 1;
    wr(3'd0, hs); wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h);
    wr(3'd4, d);  wr(3'd5, w); wr(3'd6, mo); wr(3'd7, y);
    cmd(8'hA4);
    stop_i = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset state", now_t(), mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h80, 8'h00));
  endtask

  task automatic t_load();
    stop_i = 1;
    wr(3'd2, 8'h42);
    chk("R9 load while stopped", {56'd0, min_o}, {56'd0, 8'h42});
    wr(3'd1, 8'h95);
    chk("R11 write with bit7 set keeps flag", {56'd0, sec_o}, {56'd0, 8'h95});
    wr(3'd1, 8'h15);
    chk("R11 write of 0 clears flag", {56'd0, sec_o}, {56'd0, 8'h15});
    stop_i = 0;
    @(negedge clk);
    wr(3'd2, 8'h07);
    chk("R9 load while running ignored", {56'd0, min_o}, {56'd0, 8'h42});
  endtask

  task automatic t_presc();
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h00, 8'h00, 8'h00);
    pulses(DIV - 1);
    chk("R2 no step before group ends", {56'd0, hsec_o}, 64'h00);
    pulses(1);
    chk("R2 step at group end", {56'd0, hsec_o}, 64'h01);
    pulses(2 * DIV);
    chk("R2 two more steps", {56'd0, hsec_o}, 64'h03);
  endtask

  task automatic t_carry();
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h58, 8'h59, 8'h99);
    pulses(DIV);
    chk("R3 hundredths/seconds carry", now_t(), mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h59, 8'h00, 8'h00));
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h00, 8'h19, 8'h09);
    pulses(DIV);
    chk("R3 units digit wrap", now_t(), mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h00, 8'h19, 8'h10));
  endtask

  task automatic t_24h();
    mode_12h_i = 0;
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h09, 8'h59, 8'h59, 8'h99);
    pulses(DIV);
    chk("R4 hour 09 to 10", {56'd0, hour_o}, 64'h10);
    set_time(8'h99, 8'h12, 8'h06, 8'h31, 8'h23, 8'h59, 8'h59, 8'h99);
    pulses(DIV);
    chk("R7 R4 full rollover", now_t(), mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic day_end(input logic [7:0] y, mo, d, output logic [63:0] res);
    set_time(y, mo, 8'h03, d, 8'h23, 8'h59, 8'h59, 8'h99);
    pulses(DIV);
    res = now_t();
  endtask

  task automatic t_month();
    logic [63:0] r;
    mode_12h_i = 0;
    day_end(8'h23, 8'h04, 8'h30, r);
    chk("R6 30-day month", r, mk(8'h23, 8'h05, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    day_end(8'h23, 8'h02, 8'h28, r);
    chk("R6 February common year", r, mk(8'h23, 8'h03, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    day_end(8'h24, 8'h02, 8'h28, r);
    chk("R6 February leap day", r, mk(8'h24, 8'h02, 8'h04, 8'h29, 8'h00, 8'h00, 8'h00, 8'h00));
    day_end(8'h24, 8'h02, 8'h29, r);
    chk("R6 leap February end", r, mk(8'h24, 8'h03, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    day_end(8'h00, 8'h02, 8'h28, r);
    chk("R6 year 00 is leap", r, mk(8'h00, 8'h02, 8'h04, 8'h29, 8'h00, 8'h00, 8'h00, 8'h00));
    day_end(8'h23, 8'h01, 8'h30, r);
    chk("R6 31-day month no wrap at 30", r, mk(8'h23, 8'h01, 8'h04, 8'h31, 8'h00, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic hour_step(input logic [7:0] h, output logic [63:0] res);
    set_time(8'h10, 8'h03, 8'h02, 8'h05, h, 8'h59, 8'h59, 8'h99);
    pulses(DIV);
    res = now_t();
  endtask

  task automatic t_12h();
    logic [63:0] r;
    mode_12h_i = 1;
    hour_step(8'h11, r);
    chk("R5 11 AM to 12 PM", r, mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h32, 8'h00, 8'h00, 8'h00));
    hour_step(8'h32, r);
    chk("R5 12 PM to 1 PM", r, mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h21, 8'h00, 8'h00, 8'h00));
    hour_step(8'h31, r);
    chk("R5 11 PM to 12 AM with day carry", r, mk(8'h10, 8'h03, 8'h03, 8'h06, 8'h12, 8'h00, 8'h00, 8'h00));
    hour_step(8'h12, r);
    chk("R5 12 AM to 1 AM", r, mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00));
    hour_step(8'h29, r);
    chk("R5 9 PM to 10 PM", r, mk(8'h10, 8'h03, 8'h02, 8'h05, 8'h30, 8'h00, 8'h00, 8'h00));
    mode_12h_i = 0;
  endtask

  task automatic t_stop();
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h00, 8'h00, 8'h50);
    stop_i = 1;
    pulses(5 * DIV);
    chk("R8 frozen while stopped", {56'd0, hsec_o}, 64'h50);
    stop_i = 0;
    pulses(2);
    stop_i = 1;
    pulses(7);
    stop_i = 0;
    pulses(DIV - 3);
    chk("R8 prescaler position held", {56'd0, hsec_o}, 64'h50);
    pulses(1);
    chk("R8 resumes from held position", {56'd0, hsec_o}, 64'h51);
  endtask

  task automatic t_clear();
    set_time(8'h10, 8'h03, 8'h02, 8'h05, 8'h08, 8'h00, 8'h00, 8'h20);
    pulses(DIV - 1);
    cmd(8'hA4);
    pulses(DIV - 1);
    chk("R10 clear restarts group", {56'd0, hsec_o}, 64'h20);
    pulses(1);
    chk("R10 step after full group", {56'd0, hsec_o}, 64'h21);
    pulses(DIV - 1);
    cmd(8'h55);
    pulses(1);
    chk("R10 other command no effect", {56'd0, hsec_o}, 64'h22);
    pulses(DIV - 1);
    osc_pulse_i = 1; cmd_valid_i = 1; cmd_byte_i = 8'hA4;
    @(negedge clk);
    osc_pulse_i = 0; cmd_valid_i = 0;
    chk("R10 clear beats terminal pulse", {56'd0, hsec_o}, 64'h22);
    pulses(DIV - 1);
    chk("R10 no step before new group ends", {56'd0, hsec_o}, 64'h22);
    pulses(1);
    chk("R10 step after collision", {56'd0, hsec_o}, 64'h23);
  endtask

  task automatic t_fault();
    stop_i = 1;
    osc_fault_i = 1;
    wr(3'd1, 8'h10);
    osc_fault_i = 0;
    chk("R11 fault beats clearing write", {56'd0, sec_o}, 64'h90);
    wr(3'd1, 8'h10);
    chk("R11 clearing write", {56'd0, sec_o}, 64'h10);
    stop_i = 0;
    osc_fault_i = 1;
    @(negedge clk);
    osc_fault_i = 0;
    repeat (3) @(negedge clk);
    chk("R11 flag sticky", {56'd0, sec_o}, 64'h90);
    wr(3'd1, 8'h10);
    chk("R11 running write cannot clear", {56'd0, sec_o}, 64'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load();
    t_presc();
    t_carry();
    t_24h();
    t_month();
    t_12h();
    t_stop();
    t_clear();
    t_fault();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule